// File: doc/BRIEF.md
# Ethernet Inter-Packet Gap Deferral Timer

This block decides the moment at which a transmitter sharing a medium may begin its next frame. After each transmission attempt ends, or after a backoff wait runs out, it holds off until carrier sense drops. It then counts 96 bit-time strobes before it grants permission. The gap has two parts. During the first 60 strobes, carrier seen on a strobe abandons the count and sends the block back to waiting for a quiet line. During the last 36 strobes the transmitter is committed. Carrier there does not stop the frame, and the grant is paired with a forced-collision indication.

In full-duplex operation carrier sense plays no part and only the 96-strobe timer applies. The counter moves only on the bit-time strobe, so the block does not depend on the ratio between the system clock and the bit rate. A separate receive-side monitor measures the idle time between incoming frames in strobes. It flags a frame that begins fewer than 28 strobes after the previous one ended, so that the frame can be discarded.

Top module: `ipg_defer_timer`

## Requirements
- R1: In half duplex, once carrier is low the block counts bit-time strobes and asserts `tx_start_o` for the clock after the 96th strobe. Clock cycles without a strobe do not advance the count.
- R2: After `tx_end_i`, in half duplex, no strobe is counted while `crs_i` stays high, so no start can occur however many strobes arrive.
- R3: Carrier high on any of strobes 1 to 60 of the gap discards the count. Counting restarts from zero once carrier is low again.
- R4: Carrier high on any of strobes 61 to 96 does not stop the gap. The start then happens on schedule with `force_col_o` high in the same cycle, even if the carrier has since dropped.
- R5: With `full_duplex_i` high, counting begins in the clock after `tx_end_i` regardless of `crs_i`, and `force_col_o` stays low.
- R6: A start requires `tx_req_i`. A gap that completes with no request leaves the block ready, and a later request starts in the next clock. Carrier while ready, in half duplex, returns the block to waiting.
- R7: `tx_start_o` is a single-cycle pulse. No further start occurs until `tx_end_i` has been seen.
- R8: `rx_short_o` pulses for one clock, in the clock after `rx_dv_i` rises, when fewer than 28 strobes elapsed since `rx_dv_i` last fell.
- R9: A spacing of 28 or more strobes, or the first frame after reset, leaves `rx_short_o` low.
- R10: During and after reset all outputs are low. The transmit side starts in the waiting state, as though a transmission had just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-clock strobe per bit time |
| crs_i | input | 1 | Carrier sense |
| full_duplex_i | input | 1 | Full-duplex mode, carrier ignored |
| tx_end_i | input | 1 | Transmission or backoff wait finished |
| tx_req_i | input | 1 | A frame is pending |
| tx_start_o | output | 1 | Permission to start a frame, one clock |
| force_col_o | output | 1 | Carrier seen in the committed window, with start |
| rx_dv_i | input | 1 | Receive frame in progress |
| rx_short_o | output | 1 | Received frame followed too closely, one clock |

## Verification
The transmit side is driven with five carrier patterns. A line that stays quiet fixes the exact start strobe. Carrier held through the strobes shows that deferral blocks counting. Carrier on strobe 60 must restart the gap, while carrier from strobe 61 onward, held or as a single pulse, must be ignored and raise the collision flag. Full duplex with carrier held high checks that carrier plays no part in that mode. A table of receive gaps brackets the 28-strobe limit at 27, 28 and 29, and also checks that the first frame after reset is never flagged.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_READY = 2'd2,
    ST_BUSY  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ipg_tx_defer.sv
module ipg_tx_defer import ipg_pkg::*; #(
  parameter int GAP_BITS   = 96,
  parameter int SENSE_BITS = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic crs_i,
  input  logic full_duplex_i,
  input  logic tx_end_i,
  input  logic tx_req_i,
  output logic tx_start_o,
  output logic force_col_o
);
  localparam int CNT_W = $clog2(GAP_BITS + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(GAP_BITS - 1);
  localparam logic [CNT_W-1:0] SENSE = CNT_W'(SENSE_BITS);

  tx_state_e st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic late_q, late_n, start_q, start_n, col_q, col_n;
  logic carrier;

  assign carrier = crs_i & ~full_duplex_i;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    late_n  = late_q;
    start_n = 1'b0;
    col_n   = 1'b0;
    unique case (st_q)
      ST_BUSY: if (tx_end_i) begin
        cnt_n  = '0;
        late_n = 1'b0;
        st_n   = full_duplex_i ? ST_COUNT : ST_WAIT;
      end
      ST_WAIT: if (!carrier) begin
        cnt_n = '0;
        st_n  = ST_COUNT;
      end
      ST_COUNT: if (bit_tick_i) begin
        if (carrier && cnt_q < SENSE) begin
          // early carrier: defer again
          cnt_n  = '0;
          late_n = 1'b0;
          st_n   = ST_WAIT;
        end else begin
          if (carrier) late_n = 1'b1;
          if (cnt_q == LAST) begin
            cnt_n = '0;
            if (tx_req_i) begin
              start_n = 1'b1;
              col_n   = late_n;
              st_n    = ST_BUSY;
            end else begin
              st_n = ST_READY;
            end
            late_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_READY: begin
        if (carrier) begin
          cnt_n = '0;
          st_n  = ST_WAIT;
        end else if (tx_req_i) begin
          start_n = 1'b1;
          st_n    = ST_BUSY;
        end
      end
      default: st_n = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT;
      cnt_q   <= '0;
      late_q  <= 1'b0;
      start_q <= 1'b0;
      col_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      late_q  <= late_n;
      start_q <= start_n;
      col_q   <= col_n;
    end
  end

  assign tx_start_o  = start_q;
  assign force_col_o = col_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);  // R1
  AST_WAIT_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |=> !tx_start_o);  // R2
  AST_COL_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_col_o |-> tx_start_o);  // R4
  AST_START_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(tx_req_i));  // R6
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);  // R7
endmodule

// File: rtl/ipg_rx_spacing.sv
module ipg_rx_spacing #(
  parameter int RX_MIN_BITS = 28
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic rx_dv_i,
  output logic rx_short_o
);
  localparam int RX_W = $clog2(RX_MIN_BITS + 1);
  localparam logic [RX_W-1:0] RX_MIN = RX_W'(RX_MIN_BITS);

  logic [RX_W-1:0] cnt_q;
  logic dv_q, seen_q, short_q;
  logic rise, fall;

  assign rise = rx_dv_i & ~dv_q;
  assign fall = ~rx_dv_i & dv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dv_q    <= 1'b0;
      seen_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      dv_q    <= rx_dv_i;
      short_q <= rise & seen_q & (cnt_q < RX_MIN);
      if (fall) begin
        cnt_q  <= '0;
        seen_q <= 1'b1;
      end else if (!rx_dv_i && bit_tick_i && cnt_q != RX_MIN) begin
        cnt_q <= cnt_q + 1'b1;  // saturates at limit
      end
    end
  end

  assign rx_short_o = short_q;

  AST_RX_SHORT_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_short_o |-> (dv_q && !$past(dv_q)));  // R8
  AST_RX_SHORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_short_o |=> !rx_short_o);  // R8
endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer #(
  parameter int GAP_BITS    = 96,
  parameter int SENSE_BITS  = 60,
  parameter int RX_MIN_BITS = 28
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic crs_i,
  input  logic full_duplex_i,
  input  logic tx_end_i,
  input  logic tx_req_i,
  output logic tx_start_o,
  output logic force_col_o,
  input  logic rx_dv_i,
  output logic rx_short_o
);
  ipg_tx_defer #(
    .GAP_BITS  (GAP_BITS),
    .SENSE_BITS(SENSE_BITS)
  ) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_tick_i   (bit_tick_i),
    .crs_i        (crs_i),
    .full_duplex_i(full_duplex_i),
    .tx_end_i     (tx_end_i),
    .tx_req_i     (tx_req_i),
    .tx_start_o   (tx_start_o),
    .force_col_o  (force_col_o)
  );

  ipg_rx_spacing #(
    .RX_MIN_BITS(RX_MIN_BITS)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_tick_i(bit_tick_i),
    .rx_dv_i   (rx_dv_i),
    .rx_short_o(rx_short_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !tx_start_o && !force_col_o && !rx_short_o);  // R10
endmodule

// File: tb/ipg_defer_timer_tb_top.sv
`timescale 1ns/1ps
module ipg_defer_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, crs = 1'b0, fd = 1'b0, tx_end = 1'b0, tx_req = 1'b0, rx_dv = 1'b0;
  logic tx_start, force_col, rx_short;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ipg_defer_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(bit_tick), .crs_i(crs),
    .full_duplex_i(fd), .tx_end_i(tx_end), .tx_req_i(tx_req),
    .tx_start_o(tx_start), .force_col_o(force_col),
    .rx_dv_i(rx_dv), .rx_short_o(rx_short)
  );

  // [15:8] idle strobes between frames, [0] expected short flag
  localparam logic [15:0] RX_VEC [6] = '{
    {8'd0, 8'd1}, {8'd5, 8'd1}, {8'd27, 8'd1},
    {8'd28, 8'd0}, {8'd29, 8'd0}, {8'd60, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic end_tx;
    tx_end = 1'b1;
    idle(1);
    tx_end = 1'b0;
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 start in reset", int'(tx_start), 0);
    chk("R10 col in reset", int'(force_col), 0);
    chk("R10 short in reset", int'(rx_short), 0);
    rst_n = 1'b1;
    idle(1);
    tx_req = 1'b1;
    idle(200);
    chk("R1 no count without strobe", int'(tx_start), 0);
    tick(95);
    chk("R1 before 96th strobe", int'(tx_start), 0);
    tick(1);
    chk("R1 start on 96th strobe", int'(tx_start), 1);
    chk("R1 no collision", int'(force_col), 0);
    idle(1);
    chk("R7 single-cycle start", int'(tx_start), 0);
    tick(100);
    chk("R7 no start while busy", int'(tx_start), 0);

    crs = 1'b1;
    end_tx();
    tick(120);
    chk("R2 carrier blocks count", int'(tx_start), 0);
    crs = 1'b0;
    idle(1);
    tick(59);
    crs = 1'b1;
    tick(1);
    crs = 1'b0;
    idle(1);
    tick(95);
    chk("R3 restart after early carrier", int'(tx_start), 0);
    tick(1);
    chk("R3 start after fresh gap", int'(tx_start), 1);

    end_tx();
    tick(60);
    crs = 1'b1;
    tick(35);
    chk("R4 late carrier ignored", int'(tx_start), 0);
    tick(1);
    chk("R4 start despite carrier", int'(tx_start), 1);
    chk("R4 forced collision", int'(force_col), 1);
    crs = 1'b0;

    end_tx();
    tick(70);
    crs = 1'b1;
    tick(1);
    crs = 1'b0;
    tick(25);
    chk("R4 pulse start", int'(tx_start), 1);
    chk("R4 pulse collision latched", int'(force_col), 1);

    fd = 1'b1;
    crs = 1'b1;
    tx_end = 1'b1;
    idle(1);
    tx_end = 1'b0;
    tick(95);
    chk("R5 full duplex before gap", int'(tx_start), 0);
    tick(1);
    chk("R5 full duplex start", int'(tx_start), 1);
    chk("R5 full duplex no collision", int'(force_col), 0);
    fd = 1'b0;
    crs = 1'b0;

    tx_req = 1'b0;
    end_tx();
    tick(96);
    chk("R6 no request no start", int'(tx_start), 0);
    idle(5);
    chk("R6 ready holds", int'(tx_start), 0);
    tx_req = 1'b1;
    idle(1);
    chk("R6 request from ready", int'(tx_start), 1);

    tx_req = 1'b0;
    end_tx();
    tick(96);
    crs = 1'b1;
    idle(1);
    tx_req = 1'b1;
    idle(3);
    chk("R6 carrier while ready defers", int'(tx_start), 0);
    crs = 1'b0;
    idle(1);
    tick(95);
    chk("R6 regap before start", int'(tx_start), 0);
    tick(1);
    chk("R6 start after regap", int'(tx_start), 1);
    tx_req = 1'b0;

    rx_dv = 1'b1;
    idle(1);
    chk("R9 first frame not flagged", int'(rx_short), 0);
    idle(3);
    foreach (RX_VEC[i]) begin
      rx_dv = 1'b0;
      idle(1);
      tick(int'(RX_VEC[i][15:8]));
      rx_dv = 1'b1;
      idle(1);
      chk($sformatf("R8/R9 gap %0d", RX_VEC[i][15:8]), int'(rx_short), int'(RX_VEC[i][0]));
      idle(1);
      chk("R8 short is one clock", int'(rx_short), 0);
      idle(2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule